// File: doc/BRIEF.md
# Read-After-Write Stall Classifier

This block is a per-register scoreboard for an in-order pipeline model. Each valid step presents one retiring instruction with up to three source register slots and up to two destination register slots, every slot carrying its own valid bit, together with load, store and memory-access class bits. The block works out whether that instruction would wait on an unfinished producer, and for how many cycles. It sorts the instruction into one of three classes: no stall, one-cycle stall or two-or-more-cycle stall. It keeps running counts of both stall classes and of their total.

A mode input selects one of two timing rules. Without forwarding, every result is usable three instructions after its producer. With forwarding, an ALU result is usable two instructions later and a loaded value three instructions later. In that mode a store's data operand is not checked and a store leaves no pending result. The state that the block holds is a small count of remaining wait per register. This count is decremented by every valid step. It is cleared once a wait on that register has been charged.

Top module: `hz_raw_scoreboard`

## Requirements
- R1: After a synchronous active-high reset all counters read zero, `res_valid` is low and no register has a pending result, so the first instruction after reset is classed as no stall.
- R2: `insn_count` rises by one for each clock with `in_valid` high. With `in_valid` low no counter, result or pending entry changes.
- R3: Number the valid instructions 1, 2, 3 and so on. An enabled source whose register's ready number exceeds the current instruction's number contributes that difference (1 or 2) in cycles. Any other source contributes nothing.
- R4: The contributions of all sources are added. A sum of 0 reports `res_stall`=0, a sum of 1 reports 1 and increments `one_cyc_count`, and a sum of 2 or more reports 2 and increments `two_cyc_count`.
- R5: A source or destination slot whose valid bit is low has no effect, whatever register number it carries.
- R6: Once a stall on a register has been charged, that register's entry returns to no pending. A register named in several sources of one instruction is charged only once.
- R7: With `fwd_en`=0, every enabled destination of instruction n becomes ready at n+3. The class bits do not matter.
- R8: With `fwd_en`=1, a destination of a memory load (`is_mem`=1, `is_load`=1) becomes ready at n+3, and a destination of a non-memory instruction (`is_mem`=0) becomes ready at n+2. Any other memory instruction leaves its destination registers untouched.
- R9: With `fwd_en`=1, source slot 0 of a store (`is_mem`=1, `is_store`=1) is neither checked nor cleared. With `fwd_en`=0 the slot is checked like any other.
- R10: `raw_total` always equals `one_cyc_count` plus `two_cyc_count`.
- R11: An instruction's sources are judged before its own destinations are written, so it never waits on itself. When a register is both charged and written in one step, the new ready time is kept.
- R12: All outputs are registered. The result of the step accepted at a clock edge appears after that edge with `res_valid` high. After an idle clock `res_valid` is low and `res_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One instruction is presented this clock |
| fwd_en | input | 1 | 1 selects forwarding timing, 0 selects no forwarding |
| src_vld | input | 3 | Valid bit per source slot, bit k for slot k |
| src_idx | input | 15 | Source register numbers, slot k at bits [5k+4:5k] |
| dst_vld | input | 2 | Valid bit per destination slot |
| dst_idx | input | 10 | Destination register numbers, slot k at bits [5k+4:5k] |
| is_load | input | 1 | Instruction reads memory |
| is_store | input | 1 | Instruction writes memory |
| is_mem | input | 1 | Instruction accesses memory |
| res_valid | output | 1 | A classification was made at the last edge |
| res_stall | output | 2 | 0 no stall, 1 one cycle, 2 two or more cycles |
| insn_count | output | 32 | Valid instructions seen since reset |
| one_cyc_count | output | 32 | Instructions classed as one-cycle stalls |
| two_cyc_count | output | 32 | Instructions classed as two-or-more-cycle stalls |
| raw_total | output | 32 | Sum of both stall counters |

## Verification
The hardest case to reach from the ports is a state where the pending entries interact within one step. Examples are a register charged and rewritten by the same instruction, a duplicate source whose second reading must see the cleared entry, and a skipped store data operand that must leave its pending entry to be charged by a later reader. Directed sequences set up these producer and consumer distances one instruction apart. A long random run then drawn from only four registers and mixed modes keeps many entries pending at once. A behavioural model holding absolute ready numbers is compared with every output after each clock.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        STALL_NONE = 2'd0,
        STALL_ONE  = 2'd1,
        STALL_TWO  = 2'd2
    } stall_e;

    typedef struct packed {
        logic load;
        logic store;
        logic mem;
    } iclass_t;

    // Remaining wait that the next instruction will see for a fresh result.
    function automatic logic [1:0] fresh_residual(input logic fwd, input iclass_t c);
        if (!fwd)                 return 2'd2;
        else if (c.mem && c.load) return 2'd2;
        else if (!c.mem)          return 2'd1;
        else                      return 2'd0;
    endfunction

    function automatic stall_e classify(input logic [2:0] sum);
        if (sum == 3'd0)      return STALL_NONE;
        else if (sum == 3'd1) return STALL_ONE;
        else                  return STALL_TWO;
    endfunction

endpackage

// File: rtl/hz_ready_table.sv
module hz_ready_table
    import hz_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic [NREG-1:0]          clr_mask,
    input  logic [1:0]               dst_vld,
    input  logic [2*RIDX_W-1:0]      dst_idx,
    input  logic [1:0]               set_val,
    output logic [NREG-1:0][1:0]     resid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            resid <= '0;
        end else if (step) begin
            for (int r = 0; r < NREG; r++) begin
                logic hit;
                hit = 1'b0;
                for (int k = 0; k < 2; k++) begin
                    if (dst_vld[k] && dst_idx[k*RIDX_W +: RIDX_W] == RIDX_W'(r))
                        hit = 1'b1;
                end
                if (hit && set_val != 2'd0)
                    resid[r] <= set_val;
                else if (clr_mask[r])
                    resid[r] <= 2'd0;
                else if (resid[r] != 2'd0)
                    resid[r] <= resid[r] - 2'd1;
            end
        end
    end

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(resid));  // R2

endmodule

// File: rtl/hz_stall_eval.sv
module hz_stall_eval
    import hz_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int NSRC   = 3,
    parameter int RIDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][1:0]     resid,
    input  logic [NSRC-1:0]          src_vld,
    input  logic [NSRC*RIDX_W-1:0]   src_idx,
    input  logic                     skip_slot0,
    output stall_e                   cls,
    output logic [NREG-1:0]          clr_mask
);

    logic [NSRC-1:0]   eff;
    logic [NSRC-1:0]   dup;
    logic [RIDX_W-1:0] idx [NSRC];
    logic [2:0]        sum;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            idx[i] = src_idx[i*RIDX_W +: RIDX_W];
            eff[i] = src_vld[i] && !(i == 0 && skip_slot0);
        end
        for (int i = 0; i < NSRC; i++) begin
            dup[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (eff[j] && idx[j] == idx[i]) dup[i] = 1'b1;
            end
        end
        sum      = '0;
        clr_mask = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (eff[i] && !dup[i] && resid[idx[i]] != 2'd0) begin
                sum           = sum + 3'(resid[idx[i]]);
                clr_mask[idx[i]] = 1'b1;
            end
        end
        cls = classify(sum);
    end

endmodule

// File: rtl/hz_tally.sv
module hz_tally
    import hz_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  stall_e           cls,
    output logic             res_valid,
    output logic [1:0]       res_stall,
    output logic [CNT_W-1:0] insn_count,
    output logic [CNT_W-1:0] one_cyc_count,
    output logic [CNT_W-1:0] two_cyc_count,
    output logic [CNT_W-1:0] raw_total
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_stall     <= 2'd0;
            insn_count    <= '0;
            one_cyc_count <= '0;
            two_cyc_count <= '0;
            raw_total     <= '0;
        end else begin
            res_valid <= step;
            res_stall <= step ? cls : STALL_NONE;
            if (step) begin
                insn_count <= insn_count + 1'b1;
                if (cls == STALL_ONE) one_cyc_count <= one_cyc_count + 1'b1;
                if (cls == STALL_TWO) two_cyc_count <= two_cyc_count + 1'b1;
                if (cls != STALL_NONE) raw_total <= raw_total + 1'b1;
            end
        end
    end

    AST_TOTAL_SUM: assert property (@(posedge clk) disable iff (rst)
        raw_total == one_cyc_count + two_cyc_count);  // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> insn_count == $past(insn_count) + 1'b1);  // R2
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(insn_count) && $stable(one_cyc_count) && $stable(two_cyc_count));  // R2
    AST_ONE_BUMP: assert property (@(posedge clk) disable iff (rst)
        (step && cls == STALL_ONE) |=> one_cyc_count == $past(one_cyc_count) + 1'b1
                                       && $stable(two_cyc_count));  // R4
    AST_TWO_BUMP: assert property (@(posedge clk) disable iff (rst)
        (step && cls == STALL_TWO) |=> two_cyc_count == $past(two_cyc_count) + 1'b1
                                       && $stable(one_cyc_count));  // R4
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !step |=> !res_valid && res_stall == 2'd0);  // R12

endmodule

// File: rtl/hz_raw_scoreboard.sv
module hz_raw_scoreboard
    import hz_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int CNT_W  = 32,
    localparam int RIDX_W = $clog2(NREG),
    localparam int NSRC   = 3,
    localparam int NDST   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     fwd_en,
    input  logic [NSRC-1:0]          src_vld,
    input  logic [NSRC*RIDX_W-1:0]   src_idx,
    input  logic [NDST-1:0]          dst_vld,
    input  logic [NDST*RIDX_W-1:0]   dst_idx,
    input  logic                     is_load,
    input  logic                     is_store,
    input  logic                     is_mem,
    output logic                     res_valid,
    output logic [1:0]               res_stall,
    output logic [CNT_W-1:0]         insn_count,
    output logic [CNT_W-1:0]         one_cyc_count,
    output logic [CNT_W-1:0]         two_cyc_count,
    output logic [CNT_W-1:0]         raw_total
);

    iclass_t              iclass;
    logic [NREG-1:0][1:0] resid;
    logic [NREG-1:0]      clr_mask;
    stall_e               cls;
    logic                 skip_slot0;
    logic [1:0]           set_val;

    assign iclass     = '{load: is_load, store: is_store, mem: is_mem};
    assign skip_slot0 = fwd_en && is_mem && is_store;
    assign set_val    = fresh_residual(fwd_en, iclass);

    hz_stall_eval #(.NREG(NREG), .NSRC(NSRC), .RIDX_W(RIDX_W)) u_eval (
        .resid      (resid),
        .src_vld    (src_vld),
        .src_idx    (src_idx),
        .skip_slot0 (skip_slot0),
        .cls        (cls),
        .clr_mask   (clr_mask)
    );

    hz_ready_table #(.NREG(NREG), .RIDX_W(RIDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .clr_mask (clr_mask),
        .dst_vld  (dst_vld),
        .dst_idx  (dst_idx),
        .set_val  (set_val),
        .resid    (resid)
    );

    hz_tally #(.CNT_W(CNT_W)) u_tally (
        .clk           (clk),
        .rst           (rst),
        .step          (in_valid),
        .cls           (cls),
        .res_valid     (res_valid),
        .res_stall     (res_stall),
        .insn_count    (insn_count),
        .one_cyc_count (one_cyc_count),
        .two_cyc_count (two_cyc_count),
        .raw_total     (raw_total)
    );

    AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && in_valid) |=> res_stall == 2'd0);  // R1
    AST_STORE_SKIP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && skip_slot0 && src_vld == 3'b001) |=> res_stall == 2'd0);  // R9
    AST_STALL_CODE: assert property (@(posedge clk) disable iff (rst)
        res_stall != 2'd3);  // R4

endmodule

// File: tb/hz_raw_scoreboard_bench.sv
`timescale 1ns/1ps
module hz_raw_scoreboard_bench;

    localparam int NREG = 32;
    localparam int RW   = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, fwd_en, is_load, is_store, is_mem;
    logic [2:0]    src_vld;
    logic [3*RW-1:0] src_idx;
    logic [1:0]    dst_vld;
    logic [2*RW-1:0] dst_idx;
    logic          res_valid;
    logic [1:0]    res_stall;
    logic [31:0]   insn_count, one_cyc_count, two_cyc_count, raw_total;

    always #10 clk = ~clk;

    hz_raw_scoreboard u_hz_raw_scoreboard (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fwd_en(fwd_en),
        .src_vld(src_vld), .src_idx(src_idx), .dst_vld(dst_vld), .dst_idx(dst_idx),
        .is_load(is_load), .is_store(is_store), .is_mem(is_mem),
        .res_valid(res_valid), .res_stall(res_stall), .insn_count(insn_count),
        .one_cyc_count(one_cyc_count), .two_cyc_count(two_cyc_count), .raw_total(raw_total)
    );

    int total_checks = 0;
    int bad_checks   = 0;
    bit finished     = 0;

    // behavioural model: absolute ready numbers, 0 means nothing pending
    int ready [NREG];
    int n_cur, m_one, m_two, m_stall;
    bit m_rv;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "insn_count", insn_count, n_cur);
        chk(tag, "one_cyc_count", one_cyc_count, m_one);
        chk(tag, "two_cyc_count", two_cyc_count, m_two);
        chk({tag, "/R10"}, "raw_total", raw_total, m_one + m_two);
        chk({tag, "/R12"}, "res_valid", res_valid, m_rv);
        chk(tag, "res_stall", res_stall, m_stall);
    endtask

    task automatic model(input bit v, input bit fwd, input bit [2:0] sv, input int s[3],
                         input bit [1:0] dv, input int d[2], input bit ld, input bit st, input bit mem);
        int sum;
        if (!v) begin
            m_rv = 0; m_stall = 0;
            return;
        end
        n_cur++;
        sum = 0;
        for (int i = 0; i < 3; i++) begin
            if (sv[i] && !(i == 0 && fwd && st && mem) && ready[s[i]] > n_cur) begin
                sum += ready[s[i]] - n_cur;
                ready[s[i]] = 0;
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (dv[k]) begin
                if (!fwd)            ready[d[k]] = n_cur + 3;
                else if (mem && ld)  ready[d[k]] = n_cur + 3;
                else if (!mem)       ready[d[k]] = n_cur + 2;
            end
        end
        m_rv = 1;
        m_stall = (sum == 0) ? 0 : (sum == 1) ? 1 : 2;
        if (m_stall == 1) m_one++;
        if (m_stall == 2) m_two++;
    endtask

    // called at a falling edge; returns at the next falling edge with outputs compared
    task automatic step(input bit v, input bit fwd, input bit [2:0] sv,
                        input int s0, input int s1, input int s2,
                        input bit [1:0] dv, input int d0, input int d1,
                        input bit ld, input bit st, input bit mem, input string tag);
        int s[3];
        int d[2];
        s[0] = s0; s[1] = s1; s[2] = s2; d[0] = d0; d[1] = d1;
        in_valid = v; fwd_en = fwd; src_vld = sv; dst_vld = dv;
        src_idx = {RW'(s2), RW'(s1), RW'(s0)};
        dst_idx = {RW'(d1), RW'(d0)};
        is_load = ld; is_store = st; is_mem = mem;
        @(posedge clk);
        model(v, fwd, sv, s, dv, d, ld, st, mem);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic alu_wr(input bit fwd, input int r, input string tag);
        step(1, fwd, 3'b000, 0, 0, 0, 2'b01, r, 0, 0, 0, 0, tag);
    endtask
    task automatic ld_wr(input bit fwd, input int r, input string tag);
        step(1, fwd, 3'b000, 0, 0, 0, 2'b01, r, 0, 1, 0, 1, tag);
    endtask
    task automatic rd(input bit fwd, input int r, input string tag);
        step(1, fwd, 3'b001, r, 0, 0, 2'b00, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic filler(input bit fwd);
        step(1, fwd, 3'b001, 31, 0, 0, 2'b00, 0, 0, 0, 0, 0, "filler");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) ready[r] = 0;
        n_cur = 0; m_one = 0; m_two = 0; m_stall = 0; m_rv = 0;
        rst = 1; in_valid = 0; fwd_en = 0; src_vld = '0; src_idx = '0;
        dst_vld = '0; dst_idx = '0; is_load = 0; is_store = 0; is_mem = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1 reset");
        rst = 0;

        // R1: first instruction sees nothing pending
        rd(0, 5, "R1 first");
        chk("R1", "stall first", res_stall, 0);

        // R3/R4/R7: no forwarding, distance 2 then distance 1
        alu_wr(0, 1, "R7 wr");
        rd(0, 1, "R3 dist2");
        chk("R3", "stall dist2", res_stall, 2);
        alu_wr(0, 2, "R7 wr");
        filler(0);
        rd(0, 2, "R3 dist1");
        chk("R4", "stall dist1", res_stall, 1);

        // R6: cleared after charge, duplicate sources charged once
        alu_wr(0, 3, "R6 wr");
        rd(0, 3, "R6 first");
        rd(0, 3, "R6 again");
        chk("R6", "stall after clear", res_stall, 0);
        alu_wr(0, 4, "R6 wr");
        filler(0);
        step(1, 0, 3'b011, 4, 4, 0, 2'b00, 0, 0, 0, 0, 0, "R6 dup");
        chk("R6", "dup charged once", res_stall, 1);

        // R4: sums of contributions
        step(1, 0, 3'b000, 0, 0, 0, 2'b11, 7, 8, 0, 0, 0, "R4 wr2");
        filler(0);
        step(1, 0, 3'b011, 7, 8, 0, 2'b00, 0, 0, 0, 0, 0, "R4 1+1");
        chk("R4", "sum two", res_stall, 2);
        alu_wr(0, 5, "R4 wr");
        alu_wr(0, 6, "R4 wr");
        step(1, 0, 3'b110, 0, 5, 6, 2'b00, 0, 0, 0, 0, 0, "R4 1+2");
        chk("R4", "sum three", res_stall, 2);

        // R5: disabled slots
        alu_wr(0, 9, "R5 wr");
        step(1, 0, 3'b000, 9, 9, 9, 2'b00, 0, 0, 0, 0, 0, "R5 src off");
        chk("R5", "src off", res_stall, 0);
        step(1, 0, 3'b000, 0, 0, 0, 2'b00, 10, 10, 0, 0, 0, "R5 dst off");
        rd(0, 10, "R5 rd");
        chk("R5", "dst off", res_stall, 0);

        // R8: forwarding ready times
        alu_wr(1, 11, "R8 alu");
        rd(1, 11, "R8 alu rd");
        chk("R8", "alu fwd", res_stall, 1);
        ld_wr(1, 12, "R8 load");
        rd(1, 12, "R8 load rd");
        chk("R8", "load fwd", res_stall, 2);
        step(1, 1, 3'b000, 0, 0, 0, 2'b01, 13, 0, 0, 1, 1, "R8 store");
        rd(1, 13, "R8 store rd");
        chk("R8", "store no ready", res_stall, 0);

        // R9: store data slot
        alu_wr(1, 14, "R9 wr");
        step(1, 1, 3'b001, 14, 0, 0, 2'b00, 0, 0, 0, 1, 1, "R9 skip");
        chk("R9", "skipped fwd", res_stall, 0);
        alu_wr(0, 15, "R9 wr");
        step(1, 0, 3'b001, 15, 0, 0, 2'b00, 0, 0, 0, 1, 1, "R9 nofwd");
        chk("R9", "checked nofwd", res_stall, 2);
        ld_wr(1, 16, "R9 ld");
        step(1, 1, 3'b001, 16, 0, 0, 2'b00, 0, 0, 0, 1, 1, "R9 skip ld");
        rd(1, 16, "R9 later");
        chk("R9", "skip left pending", res_stall, 1);

        // R11: own destination, write wins over clear
        step(1, 0, 3'b001, 17, 0, 0, 2'b01, 17, 0, 0, 0, 0, "R11 self");
        chk("R11", "no self wait", res_stall, 0);
        rd(0, 17, "R11 after self");
        chk("R11", "self written", res_stall, 2);
        alu_wr(0, 18, "R11 wr");
        step(1, 0, 3'b001, 18, 0, 0, 2'b01, 18, 0, 0, 0, 0, "R11 rw");
        rd(0, 18, "R11 rewrite kept");
        chk("R11", "rewrite kept", res_stall, 2);

        // R2: idle clocks with junk on the inputs, then pending entry still intact
        alu_wr(0, 19, "R2 wr");
        step(0, 1, 3'b111, 19, 19, 19, 2'b11, 19, 20, 1, 0, 1, "R2 idle");
        step(0, 0, 3'b111, 19, 19, 19, 2'b11, 19, 20, 0, 0, 0, "R2 idle");
        rd(0, 19, "R2 after idle");
        chk("R2", "entry frozen while idle", res_stall, 2);

        // random mix over a narrow register range
        for (int t = 0; t < 3000; t++) begin
            int c;
            bit ld, st, mem;
            c = $urandom_range(0, 3);
            mem = (c >= 2);
            ld  = (c == 2);
            st  = (c == 3);
            step(($urandom_range(0, 9) != 0), $urandom_range(0, 1), 3'($urandom_range(0, 7)),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 3),
                 ld, st, mem, "R3 R4 R6 R8 R9 random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule